// File: doc/BRIEF.md
# Serial Flag Offset Loader

This block keeps the two threshold offsets that a synchronous FIFO compares against its fill level to raise its almost-empty and almost-full flags. The offsets are written one bit at a time through a serial pin, clocked by the FIFO's write clock. A single stream of bits fills the empty offset first and then the full offset. The host can pause the stream at any bit, run ordinary FIFO writes, and then resume loading where it stopped.

Once a stream has begun, neither threshold may be trusted until the whole stream has arrived. The block reports this with one validity indication for each flag. The almost-full indication lives in the write domain. The almost-empty indication is synchronised into the read domain, so each indication has its own latency. A write-permission qualifier tells the FIFO when the control pins leave the write path free for normal data.

Top module: `serial_offset_loader`

## Requirements
- R1: After reset, the bit position is zero, the offsets hold their parameter defaults (127 each for the default 17-bit width), and both validity outputs are high.
- R2: A bit is taken from `ser_bit` on a rising `wclk` edge only when `ld_n` and `sen_n` are both low. Stream bit k lands in `empty_ofs[k]` for k < 17, and in `full_ofs[k-17]` for 17 <= k <= 33.
- R3: While `ld_n` is low and `sen_n` is high, neither offset changes.
- R4: Driving either `ld_n` or `sen_n` high pauses loading. When both are low again, the next bit goes to the position after the last one taken.
- R5: `wr_ok` is high exactly when `ld_n` and `sen_n` are both high.
- R6: Each accepted bit other than the last of the stream marks the set incomplete. `full_ok` goes low two `wclk` edges after that bit, and `empty_ok` goes low two `rclk` edges after it.
- R7: After the 34th bit, `full_ok` is low right after that edge and after the next edge, and is high after the second following `wclk` edge.
- R8: After the 34th bit, `empty_ok` is still low after the first following `rclk` edge and is high after the second.
- R9: After the 34th bit the position returns to zero, so a new 34-bit stream replaces both offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| ld_n | input | 1 | Load select, active low |
| sen_n | input | 1 | Serial enable, active low |
| ser_bit | input | 1 | Serial offset data |
| empty_ofs | output | 17 | Almost-empty offset |
| full_ofs | output | 17 | Almost-full offset |
| full_ok | output | 1 | Almost-full offset valid (write domain) |
| empty_ok | output | 1 | Almost-empty offset valid (read domain) |
| wr_ok | output | 1 | FIFO write path free of offset loading |

## Verification
Two events can fall on the same write edge: the last bit of one stream completes the offset set, and on the following edges the first bit of a new stream invalidates it again. Because validity runs through a two-edge pipeline, the rising and falling edges of `full_ok` can overlap in flight. Random bursts of enabled and paused cycles create these overlaps, and a bench model of the bit position and the validity pipeline judges `full_ok` on every cycle. Directed streams with pauses of both kinds check the read-domain latency of `empty_ok`, measured by counting `rclk` edges after the completing bit.

// File: rtl/ofl_pkg.sv
package ofl_pkg;

   // Offsets in one serial stream: empty first, then full
   localparam int unsigned OFL_FIELDS = 2;

   function automatic int unsigned ofl_cnt_width(input int unsigned total);
      return (total < 2) ? 1 : $clog2(total);
   endfunction

endpackage

// File: rtl/ofl_seq.sv
module ofl_seq #(
   parameter int unsigned TOTAL = 34,
   parameter int unsigned CW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift,
   output logic [CW-1:0] pos,
   output logic          set_done
);

   localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

   logic at_last;
   assign at_last = (pos == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos      <= '0;
         set_done <= 1'b1;
      end else if (shift) begin
         pos      <= at_last ? '0 : pos + 1'b1;
         set_done <= at_last;
      end
   end

   p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pos <= LAST);
   p_pos_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !shift |=> $stable(pos));
   p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && at_last) |=> (pos == '0) && set_done);
   p_incomplete_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !at_last) |=> !set_done);

endmodule

// File: rtl/ofl_store.sv
module ofl_store #(
   parameter int unsigned  TOTAL = 34,
   parameter int unsigned  CW    = 6,
   parameter logic [TOTAL-1:0] INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift,
   input  logic [CW-1:0]    pos,
   input  logic             din,
   output logic [TOTAL-1:0] word
);

   for (genvar i = 0; i < TOTAL; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word[i] <= INIT[i];
         else if (shift && (pos == CW'(i)))
            word[i] <= din;
      end
   end

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !shift |=> $stable(word));

endmodule

// File: rtl/ofl_sync.sv
module ofl_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= {STAGES{RST_VAL}};
      else        st <= {st[STAGES-2:0], d};
   end

   assign q = st[STAGES-1];

   p_stage_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st[STAGES-1] != $past(st[STAGES-1])) |-> (st[STAGES-1] == $past(st[STAGES-2])));

endmodule

// File: rtl/serial_offset_loader.sv
module serial_offset_loader #(
   parameter int unsigned        OFS_W       = 17,
   parameter int unsigned        SYNC_STAGES = 2,
   parameter logic [OFS_W-1:0]   EMPTY_INIT  = 17'd127,
   parameter logic [OFS_W-1:0]   FULL_INIT   = 17'd127
) (
   input  logic             wclk,
   input  logic             rclk,
   input  logic             rst_n,
   input  logic             ld_n,
   input  logic             sen_n,
   input  logic             ser_bit,
   output logic [OFS_W-1:0] empty_ofs,
   output logic [OFS_W-1:0] full_ofs,
   output logic             full_ok,
   output logic             empty_ok,
   output logic             wr_ok
);
   import ofl_pkg::*;

   localparam int unsigned TOTAL = OFL_FIELDS * OFS_W;
   localparam int unsigned CW    = ofl_cnt_width(TOTAL);

   if (OFS_W < 2) begin : g_bad_width
      $error("OFS_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic             shift;
   logic [CW-1:0]    pos;
   logic             set_done;
   logic [TOTAL-1:0] word;

   assign shift = !ld_n && !sen_n;
   assign wr_ok = ld_n && sen_n;

   ofl_seq #(.TOTAL(TOTAL), .CW(CW)) u_seq (
      .clk(wclk), .rst_n(rst_n), .shift(shift), .pos(pos), .set_done(set_done)
   );

   ofl_store #(.TOTAL(TOTAL), .CW(CW), .INIT({FULL_INIT, EMPTY_INIT})) u_store (
      .clk(wclk), .rst_n(rst_n), .shift(shift), .pos(pos), .din(ser_bit), .word(word)
   );

   assign empty_ofs = word[OFS_W-1:0];
   assign full_ofs  = word[TOTAL-1:OFS_W];

   ofl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wsync (
      .clk(wclk), .rst_n(rst_n), .d(set_done), .q(full_ok)
   );

   ofl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rsync (
      .clk(rclk), .rst_n(rst_n), .d(set_done), .q(empty_ok)
   );

   p_wr_blocks_load_r5: assert property (@(posedge wclk) disable iff (!rst_n)
      wr_ok |=> $stable(word));

endmodule

// File: tb/serial_offset_loader_test.sv
`timescale 1ns/1ps
module serial_offset_loader_test;

   localparam int W = 17;
   localparam int T = 2 * W;

   logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
   logic ld_n = 1'b1, sen_n = 1'b1, ser_bit = 1'b0;
   logic [W-1:0] empty_ofs, full_ofs;
   logic full_ok, empty_ok, wr_ok;

   int checks = 0, errors = 0;

   logic [T-1:0] m_word;
   int           m_pos;
   logic         m_done, m_s0, m_s1;

   always #4    wclk = ~wclk;
   always #6.5  rclk = ~rclk;

   serial_offset_loader uut (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ld_n(ld_n), .sen_n(sen_n),
      .ser_bit(ser_bit), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
      .full_ok(full_ok), .empty_ok(empty_ok), .wr_ok(wr_ok)
   );

   function automatic logic exp_wr(input logic l, input logic s);
      return l && s;
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic apply_bit(input logic b);
      m_word[m_pos] = b;
      if (m_pos == T - 1) begin
         m_pos  = 0;
         m_done = 1'b1;
      end else begin
         m_pos++;
         m_done = 1'b0;
      end
   endtask

   // Called at a negedge of wclk; drives, passes one posedge, checks at next negedge
   task automatic step(input logic l, input logic s, input logic b);
      ld_n = l; sen_n = s; ser_bit = b;
      @(posedge wclk);
      m_s1 = m_s0;
      m_s0 = m_done;
      if (!l && !s) apply_bit(b);
      @(negedge wclk);
      chk("R2/R3/R4 empty_ofs", empty_ofs, m_word[W-1:0]);
      chk("R2/R3/R4/R9 full_ofs", full_ofs, m_word[T-1:W]);
      chk("R5 wr_ok", W'(wr_ok), W'(exp_wr(l, s)));
      chk("R6/R7 full_ok", W'(full_ok), W'(m_s1));
   endtask

   // Directed stream with pauses; last bit measured against rclk edges
   task automatic load_stream(input logic [T-1:0] val);
      for (int k = 0; k < T - 1; k++) begin
         if (k == 5)  step(1'b0, 1'b1, ~val[k]);   // R3 pause, bit ignored
         if (k == 20) step(1'b1, 1'b0, ~val[k]);   // R4 pause other way
         if (k == 9)  step(1'b1, 1'b1, ~val[k]);   // R5 write window
         step(1'b0, 1'b0, val[k]);
      end
      chk("R6 empty_ok low mid stream", W'(empty_ok), W'(0));
      ld_n = 1'b0; sen_n = 1'b0; ser_bit = val[T-1];
      @(posedge wclk);
      apply_bit(val[T-1]);
      fork
         begin #1; ld_n = 1'b1; sen_n = 1'b1; end
         begin
            @(posedge rclk); #1;
            chk("R8 empty_ok after one rclk edge", W'(empty_ok), W'(0));
            @(posedge rclk); #1;
            chk("R8 empty_ok after two rclk edges", W'(empty_ok), W'(1));
         end
      join
      m_s0 = m_done; m_s1 = m_done;
      @(negedge wclk);
      chk("R9 empty_ofs", empty_ofs, val[W-1:0]);
      chk("R9 full_ofs", full_ofs, val[T-1:W]);
      chk("R7 full_ok settled", W'(full_ok), W'(1));
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      m_word = {17'd127, 17'd127};
      m_pos = 0; m_done = 1'b1; m_s0 = 1'b1; m_s1 = 1'b1;
      repeat (3) @(negedge wclk);
      rst_n = 1'b1;
      @(negedge wclk);
      chk("R1 empty_ofs default", empty_ofs, 17'd127);
      chk("R1 full_ofs default", full_ofs, 17'd127);
      chk("R1 full_ok", W'(full_ok), W'(1));
      chk("R1 empty_ok", W'(empty_ok), W'(1));
      chk("R5 wr_ok idle", W'(wr_ok), W'(1));

      // R7 exact latency: last bit of a stream, then hold
      load_stream({17'h1A5C3, 17'h0F0F1});

      // R6/R7 overlap: finish a stream, restart at once
      for (int k = 0; k < T; k++) step(1'b0, 1'b0, k[0]);
      step(1'b0, 1'b0, 1'b1);
      step(1'b1, 1'b1, 1'b0);
      step(1'b1, 1'b1, 1'b0);
      for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b0);
      chk("R6 empty_ok low after restart", W'(empty_ok), W'(0));

      for (int n = 0; n < 3000; n++) begin
         logic [2:0] r;
         r = 3'($urandom);
         step(r[2] & r[1], r[2] & r[0], 1'($urandom));
      end

      // finish the partial stream, then a fresh one (R9)
      while (m_pos != 0) step(1'b0, 1'b0, 1'($urandom));
      for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 1'b0);
      load_stream({17'h00001, 17'h1FFFF});

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule